// File: doc/BRIEF.md
# Circular Return Address Stack

This block predicts the targets of function returns in an instruction fetch unit. When a call is fetched, the front end raises a push strobe with the PC of the call. The block stores the address that follows the call, which is the call PC plus a fixed instruction size. When a return is fetched, the front end raises a pop strobe. The most recently stored address is then offered as the predicted target and removed from the stack.

The storage is a fixed ring of slots and the block never stalls. Calls that nest deeper than the ring overwrite the oldest stored addresses. A pop on an empty stack does not disturb the stack. In that case the prediction is marked invalid and an underflow flag is raised. The top entry is readable combinationally, so a return can be predicted in the same cycle that its pop strobe is seen.

Top module: `ras_top`

## Requirements
- R1: After reset, `occ_o` is 0, `top_valid_o` is 0 and `underflow_o` is 0 while no pop is requested.
- R2: A push without a pop stores `call_pc_i + INSN_BYTES` as the new top, and `occ_o` rises by one.
- R3: The top entry appears on `top_addr_o` combinationally. During a pop that has a non-empty stack, `top_valid_o` is 1 and `top_addr_o` is the prediction in that same cycle.
- R4: A pop without a push removes the top entry, so the entry pushed before it becomes the new top. Entries come back in last-in-first-out order, and `occ_o` falls by one.
- R5: `occ_o` saturates at `DEPTH`. A push on a full stack overwrites the oldest entry. After any number of pushes, only the last `DEPTH` addresses can be popped, newest first.
- R6: A pop on an empty stack gives `top_valid_o`=0 and `underflow_o`=1. `occ_o` stays 0 and the slot pointer does not move. A later push followed by a pop returns the newly pushed address.
- R7: A push and a pop in the same cycle predict the current top. They then replace the top in place with the new return address, and `occ_o` does not change. If the stack was empty, the prediction is invalid, `underflow_o` is 1 and `occ_o` becomes 1.
- R8: In a cycle with neither strobe, `call_pc_i` is ignored, and `top_addr_o` and `occ_o` keep their values.
- R9: The return address is computed modulo 2^`AW`, so a call PC near the top of the address space wraps around to a small address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Call seen: store the return address |
| call_pc_i | input | AW | PC of the call instruction |
| pop_i | input | 1 | Return seen: consume the top entry |
| top_addr_o | output | AW | Current top entry, which is the predicted return target |
| top_valid_o | output | 1 | Stack is not empty, so `top_addr_o` is a valid prediction |
| underflow_o | output | 1 | Pop requested while the stack is empty |
| occ_o | output | $clog2(DEPTH+1) | Number of live entries, saturating at DEPTH |

## Verification
The bench builds the block with `DEPTH`=4, `AW`=16 and `INSN_BYTES`=4. A four-entry ring lets six nested pushes wrap the pointer past slot 0 and overwrite two of the oldest entries within a few cycles. The 16-bit address width lets a call PC of 0xFFFE show the return address wrapping to 0x0002. With this small configuration, a short run also covers the full, empty, simultaneous push and pop, and idle cases.

// File: rtl/ras_pkg.sv
package ras_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_SWAP = 2'b11
  } ras_op_e;

  function automatic ras_op_e ras_decode(input logic push, input logic pop);
    ras_decode = ras_op_e'({pop, push});
  endfunction

endpackage

// File: rtl/ras_addr_gen.sv
module ras_addr_gen #(
  parameter int AW         = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic [AW-1:0] call_pc_i,
  output logic [AW-1:0] ret_addr_o
);
  localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

  // modulo 2^AW by width truncation
  assign ret_addr_o = call_pc_i + STEP;
endmodule

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl
  import ras_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ras_op_e       op_i,
  output logic [IW-1:0] tos_o,
  output logic          wr_en_o,
  output logic [IW-1:0] wr_idx_o,
  output logic [CW-1:0] occ_o
);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [IW-1:0] tos_q, tos_d, tos_inc, tos_dec;
  logic [CW-1:0] occ_q, occ_d;
  logic          empty;

  assign empty   = (occ_q == '0);
  assign tos_inc = (tos_q == LAST) ? '0 : tos_q + IW'(1);
  assign tos_dec = (tos_q == '0) ? LAST : tos_q - IW'(1);

  always_comb begin
    tos_d    = tos_q;
    occ_d    = occ_q;
    wr_en_o  = 1'b0;
    wr_idx_o = tos_q;
    unique case (op_i)
      OP_PUSH: begin
        tos_d    = tos_inc;
        wr_en_o  = 1'b1;
        wr_idx_o = tos_inc;
        if (occ_q != FULL) occ_d = occ_q + CW'(1);
      end
      OP_POP: begin
        // empty pop leaves pointer in place
        if (!empty) begin
          tos_d = tos_dec;
          occ_d = occ_q - CW'(1);
        end
      end
      OP_SWAP: begin
        wr_en_o = 1'b1;
        if (empty) occ_d = CW'(1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tos_q <= '0;
      occ_q <= '0;
    end else begin
      tos_q <= tos_d;
      occ_q <= occ_d;
    end
  end

  assign tos_o = tos_q;
  assign occ_o = occ_q;
endmodule

// File: rtl/ras_store.sv
module ras_store #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  parameter int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [AW-1:0] rd_data_o
);
  logic [AW-1:0]    slot_q [DEPTH];
  logic [DEPTH-1:0] slot_we;

  for (genvar g = 0; g < DEPTH; g++) begin : g_we
    assign slot_we[g] = wr_en_i && (wr_idx_i == IW'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (slot_we[i]) slot_q[i] <= wr_data_i;
      end
    end
  end

  assign rd_data_o = slot_q[rd_idx_i];
endmodule

// File: rtl/ras_top.sv
module ras_top
  import ras_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int AW         = 32,
  parameter int INSN_BYTES = 4,
  localparam int IW        = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] call_pc_i,
  input  logic          pop_i,
  output logic [AW-1:0] top_addr_o,
  output logic          top_valid_o,
  output logic          underflow_o,
  output logic [CW-1:0] occ_o
);
  ras_op_e       op;
  logic [AW-1:0] ret_addr;
  logic [IW-1:0] tos, wr_idx;
  logic          wr_en;
  logic [CW-1:0] occ;

  assign op = ras_decode(push_i, pop_i);

  ras_addr_gen #(.AW(AW), .INSN_BYTES(INSN_BYTES)) u_addr (
    .call_pc_i (call_pc_i),
    .ret_addr_o(ret_addr)
  );

  ras_ptr_ctrl #(.DEPTH(DEPTH), .IW(IW), .CW(CW)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .tos_o   (tos),
    .wr_en_o (wr_en),
    .wr_idx_o(wr_idx),
    .occ_o   (occ)
  );

  ras_store #(.DEPTH(DEPTH), .AW(AW), .IW(IW)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_idx_i (wr_idx),
    .wr_data_i(ret_addr),
    .rd_idx_i (tos),
    .rd_data_o(top_addr_o)
  );

  assign top_valid_o = (occ != '0);
  assign underflow_o = pop_i && (occ == '0);
  assign occ_o       = occ;
endmodule

// File: rtl/ras_chk.sv
module ras_chk #(
  parameter int DEPTH      = 16,
  parameter int AW         = 32,
  parameter int INSN_BYTES = 4,
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          push_i,
  input logic [AW-1:0] call_pc_i,
  input logic          pop_i,
  input logic [AW-1:0] top_addr_o,
  input logic          top_valid_o,
  input logic          underflow_o,
  input logic [CW-1:0] occ_o
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

  // R2
  push_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> top_valid_o && top_addr_o == $past(call_pc_i) + STEP);

  // R4
  pop_occ_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && top_valid_o) |=> occ_o == $past(occ_o) - CW'(1));

  // R5
  occ_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_o <= FULL);

  // R5
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && occ_o == FULL) |=> occ_o == FULL);

  // R6
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !top_valid_o) |=> !top_valid_o && occ_o == '0);

  // R7
  swap_occ_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && top_valid_o) |=> occ_o == $past(occ_o));

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !pop_i) |=> $stable(top_addr_o) && $stable(occ_o));

  // R6
  uflow_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> pop_i);
endmodule

bind ras_top ras_chk #(.DEPTH(DEPTH), .AW(AW), .INSN_BYTES(INSN_BYTES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .push_i     (push_i),
  .call_pc_i  (call_pc_i),
  .pop_i      (pop_i),
  .top_addr_o (top_addr_o),
  .top_valid_o(top_valid_o),
  .underflow_o(underflow_o),
  .occ_o      (occ_o)
);

// File: tb/ras_top_tb_top.sv
`timescale 1ns/1ps
module ras_top_tb_top;
  localparam int DEPTH = 4;
  localparam int AW    = 16;
  localparam int INSN  = 4;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          push_i = 1'b0;
  logic          pop_i = 1'b0;
  logic [AW-1:0] call_pc_i = '0;
  logic [AW-1:0] top_addr_o;
  logic          top_valid_o;
  logic          underflow_o;
  logic [CW-1:0] occ_o;

  int total = 0;
  int bad   = 0;

  logic [AW-1:0] model_q[$];
  logic [AW:0]   exp_q[$];   // {valid, addr}
  string         req_q[$];

  always #2 clk_i = ~clk_i;

  ras_top #(.DEPTH(DEPTH), .AW(AW), .INSN_BYTES(INSN)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push_i), .call_pc_i(call_pc_i),
    .pop_i(pop_i), .top_addr_o(top_addr_o), .top_valid_o(top_valid_o),
    .underflow_o(underflow_o), .occ_o(occ_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: applies one cycle of strobes, queues the expected prediction
  task automatic drive(input logic p, input logic o, input logic [AW-1:0] pc, input string req);
    logic [AW-1:0] ret;
    @(negedge clk_i);
    push_i = p; pop_i = o; call_pc_i = pc;
    ret = pc + AW'(INSN);
    if (o) begin
      if (model_q.size() == 0) exp_q.push_back({1'b0, {AW{1'b0}}});
      else                     exp_q.push_back({1'b1, model_q[$]});
      req_q.push_back(req);
    end
    if (p && o) begin
      if (model_q.size() == 0) model_q.push_back(ret);
      else                     model_q[$] = ret;
    end else if (p) begin
      model_q.push_back(ret);
      if (model_q.size() > DEPTH) void'(model_q.pop_front());
    end else if (o && model_q.size() != 0) begin
      void'(model_q.pop_back());
    end
  endtask

  // idle cycle: peek top and occupancy with no strobe
  task automatic idle_check(input string req, input logic [AW-1:0] noise);
    @(negedge clk_i);
    push_i = 1'b0; pop_i = 1'b0; call_pc_i = noise;
    #1;
    check(req, 32'(occ_o), 32'(model_q.size()));
    check(req, 32'(top_valid_o), 32'(model_q.size() != 0));
    check(req, 32'(underflow_o), 32'd0);
    if (model_q.size() != 0) check(req, 32'(top_addr_o), 32'(model_q[$]));
  endtask

  // monitor: compares predictions just before the capturing edge
  initial forever begin
    @(negedge clk_i);
    #1.5;
    if (pop_i && exp_q.size() != 0) begin
      logic [AW:0] e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      check(r, 32'(top_valid_o), 32'(e[AW]));
      check(r, 32'(underflow_o), 32'(!e[AW]));
      if (e[AW]) check(r, 32'(top_addr_o), 32'(e[AW-1:0]));
    end
  end

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    idle_check("R1", 16'h1234);

    drive(1, 0, 16'h1000, "R2");
    idle_check("R2", 16'h0);
    drive(1, 0, 16'h2000, "R2");
    idle_check("R2", 16'h5555);
    drive(0, 1, 16'h0, "R3");
    drive(0, 1, 16'h0, "R4");
    drive(0, 1, 16'h0, "R6");
    idle_check("R6", 16'h0);

    drive(1, 0, 16'h3000, "R6");
    idle_check("R6", 16'h0);
    drive(1, 1, 16'h4000, "R7");
    idle_check("R7", 16'h0);
    drive(0, 1, 16'h0, "R7");
    drive(1, 1, 16'h5000, "R7");
    idle_check("R7", 16'h0);
    drive(0, 1, 16'h0, "R7");

    for (int k = 1; k <= 6; k++) drive(1, 0, AW'(k * 16'h0100), "R5");
    idle_check("R5", 16'h0);
    for (int k = 0; k < 4; k++) drive(0, 1, 16'h0, "R5");
    drive(0, 1, 16'h0, "R6");
    idle_check("R5", 16'h0);

    drive(1, 0, 16'h7000, "R8");
    idle_check("R8", 16'hAAAA);
    idle_check("R8", 16'h5555);
    drive(0, 1, 16'h0, "R8");

    drive(1, 0, 16'hFFFE, "R9");
    idle_check("R9", 16'h0);
    drive(0, 1, 16'h0, "R9");
    idle_check("R4", 16'h0);

    repeat (2) @(negedge clk_i);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule